// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits between a set of device request lines and a processor. It picks the most urgent pending device, compares that device's priority against the level of the handler now running, and raises a single request to the processor. When the processor acknowledges, the controller grants the bus to the winning device and waits for that device to return a vector. It then presents the vector to the processor and records the new handler level. If the device does not answer in time, the controller reports a bus error and dispatches nothing.

A stack of in-service levels lets handlers nest. An end-of-interrupt strobe removes the top entry, so the level of the interrupted handler applies again. A separate non-maskable line is captured on its rising edge. It is taken regardless of the current level and is served with a fixed vector, without a device grant.

The controller is a five-state machine. The states are IDLE, ASK (request raised to the processor), FETCH (a device holds the grant and owes a vector), ISSUE (vector presented) and FAULT (bus error presented). The transitions are:
- *raise*: IDLE to ASK.
- *withdraw*: ASK to IDLE, taken when no candidate is left.
- *take-device*: ASK to FETCH.
- *take-nmi*: ASK to ISSUE.
- *vector-in*: FETCH to ISSUE.
- *expire*: FETCH to FAULT.
- *retire*: ISSUE or FAULT to IDLE.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, `cpu_irq`, `dev_grant`, `vec_valid`, `bus_err` and `stack_ovf` are all 0, and `cur_level` is 0.
- R2: Device line i carries level N_SRC-i; the NMI carries level N_SRC+1; level 0 means that no handler is in service. `cpu_irq` goes high one cycle after the controller, while in IDLE, samples a candidate. A candidate is either a pending NMI or a winning device whose level is strictly above `cur_level`.
- R3: Among simultaneous device requests, the lowest-numbered asserted line wins. It is chosen first and only then compared with `cur_level`. The winner at the acknowledge cycle receives a one-hot `dev_grant` bit at its own index.
- R4: A device request whose level is not above `cur_level` is ignored: `cpu_irq` stays low while it is held.
- R5: A rising edge on `nmi_req` is serviced exactly once, whatever `cur_level` is. It is served with vector `NMI_VECTOR` (default 8'hFF), with no device grant, and pushes level N_SRC+1. Holding the line high does not request again.
- R6: After `cpu_ack` is sampled in ASK, `dev_grant` stays asserted until `dev_vec_valid` is sampled. In the following cycle `vec_valid` pulses for one cycle, and `vec_out` holds the device's vector.
- R7: If no vector arrives during the VEC_TIMEOUT (16) cycles in which the grant is held, `bus_err` pulses for one cycle, the grant drops and `cur_level` is unchanged. A vector in the last of those cycles is still accepted.
- R8: A dispatch pushes the served level, and `cur_level` shows it in the same cycle as `vec_valid`.
- R9: `eoi` pops the stack, and `cur_level` returns to the previous entry, or to 0 when the stack is empty. `eoi` on an empty stack is ignored. When `eoi` and a push fall in the same cycle, the pop is applied first, so the new level replaces the top entry.
- R10: A push that finds all STACK_DEPTH (8) entries full is dropped, and `stack_ovf` goes high and stays high until reset.
- R11: If the candidate disappears while in ASK, `cpu_irq` drops the next cycle. `cpu_ack` has no effect outside ASK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_req | input | N_SRC | Level-sensitive device requests, line 0 most urgent |
| nmi_req | input | 1 | Non-maskable request, edge-captured |
| cpu_ack | input | 1 | Processor acknowledge |
| dev_vec_valid | input | 1 | Granted device presents a vector |
| dev_vec | input | VEC_W | Vector from the granted device |
| eoi | input | 1 | End-of-interrupt strobe |
| cpu_irq | output | 1 | Interrupt request to the processor |
| dev_grant | output | N_SRC | One-hot grant to the device that owes a vector |
| vec_valid | output | 1 | One-cycle vector-ready pulse |
| vec_out | output | VEC_W | Vector for the processor |
| bus_err | output | 1 | One-cycle vector timeout pulse |
| cur_level | output | clog2(N_SRC+2) | Level of the handler in service |
| stack_ovf | output | 1 | Sticky in-service stack overflow |

## Verification
The assertions assume that `dev_vec_valid` comes only from a device that holds the grant. They also assume that the processor pulses `eoi` only for a handler that was actually dispatched. The stimulus asserts `dev_vec_valid` only after the grant is seen, and raises `cpu_ack` only once `cpu_irq` is high, apart from one deliberate stray acknowledge issued in IDLE. The only extra `eoi` strobes are the deliberate pops of an already empty stack.

// File: rtl/ivc_pkg.sv
`timescale 1ns/1ps
package ivc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ASK,
        ST_FETCH,
        ST_ISSUE,
        ST_FAULT
    } ivc_state_e;

endpackage

// File: rtl/ivc_arbiter.sv
`timescale 1ns/1ps
// Fixed-priority pick: lowest-numbered asserted line wins; reports its level.
module ivc_arbiter #(
    parameter int N_SRC = 8,
    parameter int IDX_W = 3,
    parameter int LVL_W = 4
) (
    input  logic [N_SRC-1:0] req,
    output logic             any,
    output logic [IDX_W-1:0] idx,
    output logic [LVL_W-1:0] lvl
);

    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
        lvl = any ? LVL_W'(N_SRC - int'(idx)) : '0;
    end

endmodule

// File: rtl/ivc_nmi_catch.sv
`timescale 1ns/1ps
// Captures each rising edge of the non-maskable line until it is taken.
module ivc_nmi_catch (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_in,
    input  logic take,
    output logic pending
);

    logic nmi_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nmi_prev <= 1'b0;
            pending  <= 1'b0;
        end else begin
            nmi_prev <= nmi_in;
            pending  <= (nmi_in & ~nmi_prev) | (pending & ~take);
        end
    end

endmodule

// File: rtl/ivc_level_stack.sv
`timescale 1ns/1ps
// In-service level stack; a pop in the same cycle as a push is applied first.
module ivc_level_stack #(
    parameter int DEPTH = 8,
    parameter int LVL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [LVL_W-1:0] push_lvl,
    input  logic             pop,
    output logic [LVL_W-1:0] top_lvl,
    output logic             ovf
);

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [LVL_W-1:0] mem [DEPTH];
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_after_pop;
    logic [CNT_W-1:0] cnt_top;
    logic             full_after_pop;

    always_comb begin
        cnt_after_pop  = (pop && cnt != '0) ? cnt - CNT_W'(1) : cnt;
        full_after_pop = (cnt_after_pop == CNT_W'(DEPTH));
        cnt_top        = cnt - CNT_W'(1);
        top_lvl        = (cnt == '0) ? '0 : mem[cnt_top[PTR_W-1:0]];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            ovf <= 1'b0;
        end else if (push) begin
            if (full_after_pop) begin
                cnt <= cnt_after_pop;
                ovf <= 1'b1;
            end else begin
                cnt <= cnt_after_pop + CNT_W'(1);
            end
        end else begin
            cnt <= cnt_after_pop;
        end
    end

    always_ff @(posedge clk) begin
        if (push && !full_after_pop) begin
            mem[cnt_after_pop[PTR_W-1:0]] <= push_lvl;
        end
    end

endmodule

// File: rtl/irq_vector_ctrl.sv
`timescale 1ns/1ps
// Prioritized vectored interrupt controller with nesting and vector timeout.
module irq_vector_ctrl
    import ivc_pkg::*;
#(
    parameter int          N_SRC       = 8,
    parameter int          VEC_W       = 8,
    parameter int          VEC_TIMEOUT = 16,
    parameter int          STACK_DEPTH = 8,
    parameter int unsigned NMI_VECTOR  = 255
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [N_SRC-1:0]              dev_req,
    input  logic                          nmi_req,
    input  logic                          cpu_ack,
    input  logic                          dev_vec_valid,
    input  logic [VEC_W-1:0]              dev_vec,
    input  logic                          eoi,
    output logic                          cpu_irq,
    output logic [N_SRC-1:0]              dev_grant,
    output logic                          vec_valid,
    output logic [VEC_W-1:0]              vec_out,
    output logic                          bus_err,
    output logic [$clog2(N_SRC+2)-1:0]    cur_level,
    output logic                          stack_ovf
);

    localparam int LVL_W = $clog2(N_SRC + 2);
    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;
    localparam int TMR_W = (VEC_TIMEOUT > 1) ? $clog2(VEC_TIMEOUT) : 1;
    localparam logic [LVL_W-1:0] NMI_LVL  = LVL_W'(N_SRC + 1);
    localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(VEC_TIMEOUT - 1);
    localparam logic [VEC_W-1:0] NMI_VEC  = VEC_W'(NMI_VECTOR);

    ivc_state_e       state, state_nx;
    logic             arb_any;
    logic [IDX_W-1:0] arb_idx;
    logic [LVL_W-1:0] arb_lvl;
    logic             nmi_pend;
    logic             nmi_take;
    logic             cand;
    logic             push;
    logic [LVL_W-1:0] push_lvl;
    logic             grant_en;
    logic [IDX_W-1:0] gnt_idx;
    logic [LVL_W-1:0] gnt_lvl;
    logic [TMR_W-1:0] tmr;
    logic [VEC_W-1:0] vec_q;

    ivc_arbiter #(
        .N_SRC (N_SRC),
        .IDX_W (IDX_W),
        .LVL_W (LVL_W)
    ) u_arb (
        .req (dev_req),
        .any (arb_any),
        .idx (arb_idx),
        .lvl (arb_lvl)
    );

    ivc_nmi_catch u_nmi (
        .clk     (clk),
        .rst_n   (rst_n),
        .nmi_in  (nmi_req),
        .take    (nmi_take),
        .pending (nmi_pend)
    );

    ivc_level_stack #(
        .DEPTH (STACK_DEPTH),
        .LVL_W (LVL_W)
    ) u_stack (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .push_lvl (push_lvl),
        .pop      (eoi),
        .top_lvl  (cur_level),
        .ovf      (stack_ovf)
    );

    // Arbitrate first, then compare the single winner with the running level.
    assign cand = nmi_pend || (arb_any && (arb_lvl > cur_level));

    // Stack push and NMI consumption.
    always_comb begin
        nmi_take = (state == ST_ASK) && cpu_ack && nmi_pend;
        push     = nmi_take || ((state == ST_FETCH) && dev_vec_valid);
        push_lvl = (state == ST_ASK) ? NMI_LVL : gnt_lvl;
    end

    // Next-state logic.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (cand) state_nx = ST_ASK;
            end
            ST_ASK: begin
                if (!cand)         state_nx = ST_IDLE;
                else if (cpu_ack)  state_nx = nmi_pend ? ST_ISSUE : ST_FETCH;
            end
            ST_FETCH: begin
                if (dev_vec_valid)        state_nx = ST_ISSUE;
                else if (tmr == TMR_LAST) state_nx = ST_FAULT;
            end
            ST_ISSUE: state_nx = ST_IDLE;
            ST_FAULT: state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Captured grant, timer and vector.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gnt_idx <= '0;
            gnt_lvl <= '0;
            tmr     <= '0;
            vec_q   <= '0;
        end else begin
            if ((state == ST_ASK) && cpu_ack && cand && !nmi_pend) begin
                gnt_idx <= arb_idx;
                gnt_lvl <= arb_lvl;
            end
            if (state == ST_ASK)        tmr <= '0;
            else if (state == ST_FETCH) tmr <= tmr + TMR_W'(1);
            if (nmi_take)                                    vec_q <= NMI_VEC;
            else if ((state == ST_FETCH) && dev_vec_valid)   vec_q <= dev_vec;
        end
    end

    // Outputs decoded from the state.
    always_comb begin
        cpu_irq   = 1'b0;
        grant_en  = 1'b0;
        vec_valid = 1'b0;
        bus_err   = 1'b0;
        unique case (state)
            ST_IDLE:  ;
            ST_ASK:   cpu_irq   = 1'b1;
            ST_FETCH: grant_en  = 1'b1;
            ST_ISSUE: vec_valid = 1'b1;
            ST_FAULT: bus_err   = 1'b1;
            default:  ;
        endcase
    end

    assign vec_out = vec_q;

    for (genvar g = 0; g < N_SRC; g++) begin : g_grant
        assign dev_grant[g] = grant_en && (gnt_idx == IDX_W'(g));
    end

endmodule

// File: rtl/ivc_checker.sv
`timescale 1ns/1ps
module ivc_checker #(
    parameter int          N_SRC       = 8,
    parameter int          VEC_W       = 8,
    parameter int          VEC_TIMEOUT = 16,
    parameter int          STACK_DEPTH = 8,
    parameter int unsigned NMI_VECTOR  = 255
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [N_SRC-1:0]           dev_req,
    input logic                       nmi_req,
    input logic                       cpu_ack,
    input logic                       dev_vec_valid,
    input logic [VEC_W-1:0]           dev_vec,
    input logic                       eoi,
    input logic                       cpu_irq,
    input logic [N_SRC-1:0]           dev_grant,
    input logic                       vec_valid,
    input logic [VEC_W-1:0]           vec_out,
    input logic                       bus_err,
    input logic [$clog2(N_SRC+2)-1:0] cur_level,
    input logic                       stack_ovf
);

    localparam int RUN_W = $clog2(VEC_TIMEOUT + 2);

    logic [RUN_W-1:0] gnt_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 gnt_run <= '0;
        else if (dev_grant == '0)   gnt_run <= '0;
        else if (gnt_run != '1)     gnt_run <= gnt_run + RUN_W'(1);
    end

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dev_grant)); // R3

    AST_IRQ_NOT_WITH_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_irq && (dev_grant != '0))); // R6

    AST_VEC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |=> !vec_valid); // R6

    AST_BUSERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |=> !bus_err); // R7

    AST_BUSERR_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> $past(dev_grant != '0)); // R7

    AST_GRANT_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_grant != '0) |-> (gnt_run < RUN_W'(VEC_TIMEOUT))); // R7

    AST_LEVEL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cur_level) |-> (vec_valid || $past(eoi))); // R8

    AST_NO_OVERFLOW_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
        stack_ovf |=> stack_ovf); // R10

endmodule

bind irq_vector_ctrl ivc_checker #(
    .N_SRC       (N_SRC),
    .VEC_W       (VEC_W),
    .VEC_TIMEOUT (VEC_TIMEOUT),
    .STACK_DEPTH (STACK_DEPTH),
    .NMI_VECTOR  (NMI_VECTOR)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .dev_req       (dev_req),
    .nmi_req       (nmi_req),
    .cpu_ack       (cpu_ack),
    .dev_vec_valid (dev_vec_valid),
    .dev_vec       (dev_vec),
    .eoi           (eoi),
    .cpu_irq       (cpu_irq),
    .dev_grant     (dev_grant),
    .vec_valid     (vec_valid),
    .vec_out       (vec_out),
    .bus_err       (bus_err),
    .cur_level     (cur_level),
    .stack_ovf     (stack_ovf)
);

// File: tb/tb_irq_vector_ctrl.sv
`timescale 1ns/1ps
module tb_irq_vector_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] dev_req = '0;
    logic       nmi_req = 1'b0;
    logic       cpu_ack = 1'b0;
    logic       dev_vec_valid = 1'b0;
    logic [7:0] dev_vec = '0;
    logic       eoi = 1'b0;
    logic       cpu_irq;
    logic [7:0] dev_grant;
    logic       vec_valid;
    logic [7:0] vec_out;
    logic       bus_err;
    logic [3:0] cur_level;
    logic       stack_ovf;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    irq_vector_ctrl dut (
        .clk(clk), .rst_n(rst_n), .dev_req(dev_req), .nmi_req(nmi_req),
        .cpu_ack(cpu_ack), .dev_vec_valid(dev_vec_valid), .dev_vec(dev_vec),
        .eoi(eoi), .cpu_irq(cpu_irq), .dev_grant(dev_grant),
        .vec_valid(vec_valid), .vec_out(vec_out), .bus_err(bus_err),
        .cur_level(cur_level), .stack_ovf(stack_ovf)
    );

    task automatic chk(bit ok, string tag, string what, int got, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s got %0d expected %0d at %0t", tag, what, got, exp, $time);
        end
    endtask

    // Behavioural reference model: phase 0 idle, 1 ask, 2 fetch, 3 issue, 4 fault.
    int   m_phase, m_gidx, m_glvl, m_tmr;
    int   m_stk[$];
    bit   m_pend, m_prev, m_ovf;
    logic [7:0] m_vec;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_gidx = 0; m_glvl = 0; m_tmr = 0;
            m_stk.delete(); m_pend = 0; m_prev = 0; m_ovf = 0; m_vec = '0;
        end else begin
            int cur, w, wl, plvl;
            bit cand, do_push, take;
            cur = (m_stk.size() > 0) ? m_stk[$] : 0;
            w = -1;
            for (int i = 7; i >= 0; i--) if (dev_req[i]) w = i;
            wl = (w >= 0) ? 8 - w : 0;
            cand = m_pend || (w >= 0 && wl > cur);
            do_push = 0; take = 0; plvl = 0;
            case (m_phase)
                0: if (cand) m_phase = 1;
                1: begin
                    if (!cand) m_phase = 0;
                    else if (cpu_ack) begin
                        if (m_pend) begin
                            take = 1; do_push = 1; plvl = 9; m_vec = 8'hFF; m_phase = 3;
                        end else begin
                            m_gidx = w; m_glvl = wl; m_tmr = 0; m_phase = 2;
                        end
                    end
                end
                2: begin
                    if (dev_vec_valid) begin
                        m_vec = dev_vec; do_push = 1; plvl = m_glvl; m_phase = 3;
                    end else if (m_tmr == 15) m_phase = 4;
                    else m_tmr++;
                end
                default: m_phase = 0;
            endcase
            if (eoi && m_stk.size() > 0) void'(m_stk.pop_back());
            if (do_push) begin
                if (m_stk.size() == 8) m_ovf = 1;
                else m_stk.push_back(plvl);
            end
            m_pend = (nmi_req && !m_prev) || (m_pend && !take);
            m_prev = nmi_req;
        end
    end

    // Compare against the model on every cycle, away from the clock edge.
    always @(negedge clk) begin
        if (rst_n) begin
            int e_lvl;
            logic [7:0] e_gnt;
            e_lvl = (m_stk.size() > 0) ? m_stk[$] : 0;
            e_gnt = (m_phase == 2) ? (8'd1 << m_gidx) : 8'd0;
            chk(cpu_irq == (m_phase == 1), "R2", "cpu_irq", cpu_irq, m_phase == 1);
            chk(dev_grant == e_gnt, "R3", "dev_grant", dev_grant, e_gnt);
            chk(vec_valid == (m_phase == 3), "R6", "vec_valid", vec_valid, m_phase == 3);
            if (m_phase == 3) chk(vec_out == m_vec, "R6", "vec_out", vec_out, m_vec);
            chk(bus_err == (m_phase == 4), "R7", "bus_err", bus_err, m_phase == 4);
            chk(cur_level == e_lvl, "R8", "cur_level", cur_level, e_lvl);
            chk(stack_ovf == m_ovf, "R10", "stack_ovf", stack_ovf, m_ovf);
        end
    end

    task automatic tick();
        @(posedge clk);
        #4;
    endtask

    task automatic wait_irq();
        int n = 0;
        while (!cpu_irq && n < 20) begin
            tick();
            n++;
        end
        chk(cpu_irq == 1'b1, "R2", "cpu_irq raised", cpu_irq, 1);
    endtask

    task automatic serve(int line, logic [7:0] v, int lat, bit eoi_too, int exp_lvl);
        dev_req[line] = 1'b1;
        wait_irq();
        cpu_ack = 1'b1;
        tick();
        cpu_ack = 1'b0;
        chk(dev_grant == (8'd1 << line), "R3", "grant to winner", dev_grant, 8'd1 << line);
        repeat (lat) tick();
        dev_vec_valid = 1'b1;
        dev_vec = v;
        eoi = eoi_too;
        tick();
        dev_vec_valid = 1'b0;
        eoi = 1'b0;
        chk(vec_valid == 1'b1, "R6", "vec_valid", vec_valid, 1);
        chk(vec_out == v, "R6", "vec_out", vec_out, v);
        chk(cur_level == exp_lvl, "R8", "level after dispatch", cur_level, exp_lvl);
    endtask

    task automatic nmi_once();
        nmi_req = 1'b1;
        tick();
        nmi_req = 1'b0;
        wait_irq();
        cpu_ack = 1'b1;
        tick();
        cpu_ack = 1'b0;
        tick();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #4 rst_n = 1'b1;
        tick();
        // R1 reset state
        chk(cpu_irq == 0 && dev_grant == 0 && vec_valid == 0 && bus_err == 0,
            "R1", "control outputs", {cpu_irq, vec_valid, bus_err}, 0);
        chk(cur_level == 0 && stack_ovf == 0, "R1", "level/ovf", cur_level, 0);

        // Single device, then the same line held is masked (R4)
        serve(3, 8'h33, 2, 0, 5);
        repeat (6) tick();
        chk(cpu_irq == 0, "R4", "equal level masked", cpu_irq, 0);
        dev_req[3] = 1'b0;

        // Lower level masked, then simultaneous lines 1 and 2 (R3), late vector (R7)
        dev_req[5] = 1'b1;
        repeat (5) tick();
        chk(cpu_irq == 0, "R4", "lower level masked", cpu_irq, 0);
        dev_req[2] = 1'b1;
        serve(1, 8'h11, 15, 0, 7);
        dev_req = '0;

        // EOI restores the outer level (R9)
        eoi = 1'b1; tick(); eoi = 1'b0;
        chk(cur_level == 5, "R9", "level after eoi", cur_level, 5);

        // Timeout produces bus error and leaves level unchanged (R7)
        dev_req[0] = 1'b1;
        wait_irq();
        cpu_ack = 1'b1; tick(); cpu_ack = 1'b0;
        dev_req[0] = 1'b0;
        repeat (15) tick();
        chk(bus_err == 0, "R7", "no early bus_err", bus_err, 0);
        tick();
        chk(bus_err == 1, "R7", "bus_err on timeout", bus_err, 1);
        chk(cur_level == 5, "R7", "level unchanged on fault", cur_level, 5);
        tick();
        chk(bus_err == 0, "R7", "bus_err one pulse", bus_err, 0);

        // Withdrawn request and stray acknowledge (R11)
        dev_req[2] = 1'b1;
        wait_irq();
        dev_req[2] = 1'b0;
        tick();
        chk(cpu_irq == 0, "R11", "irq drops on withdraw", cpu_irq, 0);
        cpu_ack = 1'b1; tick(); cpu_ack = 1'b0; tick();
        chk(cpu_irq == 0 && dev_grant == 0, "R11", "stray ack ignored", dev_grant, 0);

        // NMI held high is served once with fixed vector (R5)
        nmi_req = 1'b1;
        wait_irq();
        cpu_ack = 1'b1; tick(); cpu_ack = 1'b0;
        chk(vec_valid == 1 && vec_out == 8'hFF, "R5", "nmi vector", vec_out, 8'hFF);
        chk(cur_level == 9 && dev_grant == 0, "R5", "nmi level", cur_level, 9);
        repeat (6) tick();
        chk(cpu_irq == 0, "R5", "held nmi not repeated", cpu_irq, 0);
        nmi_req = 1'b0;
        tick();

        // Fill the stack past its depth (R10)
        for (int k = 0; k < 7; k++) nmi_once();
        chk(stack_ovf == 1, "R10", "overflow flagged", stack_ovf, 1);
        chk(cur_level == 9, "R10", "level after overflow", cur_level, 9);

        // Drain beyond empty (R9)
        eoi = 1'b1; repeat (10) tick(); eoi = 1'b0;
        tick();
        chk(cur_level == 0, "R9", "empty after drain", cur_level, 0);
        chk(stack_ovf == 1, "R10", "overflow sticky", stack_ovf, 1);

        // EOI together with a push replaces the top (R9)
        serve(4, 8'h44, 0, 0, 4);
        dev_req[4] = 1'b0;
        serve(1, 8'h5A, 1, 1, 7);
        dev_req[1] = 1'b0;
        eoi = 1'b1; tick(); eoi = 1'b0;
        chk(cur_level == 0, "R9", "replaced entry popped", cur_level, 0);

        repeat (3) tick();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule